// File: doc/BRIEF.md
# CCD Vertical Sequence Timing Generator

This block produces the timing for one vertical readout sequence of a CCD sensor. A free-running pixel counter walks each line and marks the start of every line with an active-low line pulse. Two pattern channels each play a vertical pattern group from a small fixed table. Each channel starts at its own pixel position and repeats the group back to back for a programmed count, and that count differs between odd and even lines. Every one of the thirteen vertical clock outputs is mapped to one of the two channels. The block also derives three line-relative blanking and clamp signals from a polarity and two toggle pixels each.

The vertical outputs can be held by two freeze windows. While a window is open, every vertical output keeps its level and both pattern channels stop advancing. When the window closes they carry on from where they stopped. The whole configuration sits on a parallel port and is captured in one cycle by a frame-start strobe. The field is a programmed number of lines, and its last line has a length of its own. After the last line the block idles until the next strobe.

Top module: `vseq_timing_gen`

## Requirements
- R1: A line length value N gives a line of N+1 pixels (1 to 8192). The pixel counter runs 0..N. hd_n is low only while the counter is 0 and the field is running. The outputs for pixel p are visible in the cycle in which the counter holds p, and pixel 0 of line 0 is visible in the cycle after the clock edge that samples frame_start high.
- R2: A line count value M gives M+1 lines. Line M uses cfg_last_len_m1 in place of cfg_line_len_m1. After line M the block is idle until the next frame_start. While idle, and after reset, hd_n=1, xv=0, and clpob, pblk and hblk equal their latched polarity bits (all zero after reset).
- R3: All cfg_* inputs are sampled only at a clock edge where frame_start is high. Changes at any other time have no effect on the outputs.
- R4: Line 0 of a field is odd, and the parity flips at every line. Odd lines use cfg_rep_odd and even lines use cfg_rep_even as the number of back-to-back plays of the group. A count of 0 plays nothing.
- R5: Group g (0..3) has length 6+2g pixels. For output index k (xv bit k, 0..12) it has start level (k mod 2) XOR (g mod 2), and toggle offsets t1 = 1+((k+g) mod 3) and t2 = t1+2+g. At pattern offset q the level is the start level, inverted once for each toggle offset that q has reached.
- R6: Channel A plays group cfg_grp_a from pixel cfg_start_a, and channel B plays group cfg_grp_b from pixel cfg_start_b. xv bit k follows channel B when cfg_use_b bit k is 1, and channel A otherwise. A channel that is not playing shows the start levels of its group. Play is cut off at the end of the line.
- R7: On a running line, clpob, pblk and hblk each equal their polarity bit, inverted once for each of their two toggle pixels that the pixel counter has reached.
- R8: Freeze window i (i=1,2) is enabled by cfg_frz_en bit i-1 and covers pixels from its freeze pixel up to, but not including, its resume pixel. In a covered pixel, xv repeats its level from the previous cycle and the pattern offsets do not advance. When the window ends, play resumes at the next offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Latches configuration and starts a field |
| cfg_line_len_m1 | input | 13 | Normal line length minus one |
| cfg_last_len_m1 | input | 13 | Last-line length minus one |
| cfg_last_line | input | 8 | Index of the last line of the field |
| cfg_grp_a | input | 2 | Pattern group of channel A |
| cfg_grp_b | input | 2 | Pattern group of channel B |
| cfg_start_a | input | 13 | Start pixel of channel A |
| cfg_start_b | input | 13 | Start pixel of channel B |
| cfg_use_b | input | 13 | Per-output channel B select |
| cfg_rep_odd | input | 4 | Plays per odd line |
| cfg_rep_even | input | 4 | Plays per even line |
| cfg_clpob_pol | input | 1 | Clamp start polarity |
| cfg_clpob_t1 | input | 13 | Clamp first toggle pixel |
| cfg_clpob_t2 | input | 13 | Clamp second toggle pixel |
| cfg_pblk_pol | input | 1 | Pre-blank start polarity |
| cfg_pblk_t1 | input | 13 | Pre-blank first toggle pixel |
| cfg_pblk_t2 | input | 13 | Pre-blank second toggle pixel |
| cfg_hblk_pol | input | 1 | Horizontal blank masking polarity |
| cfg_hblk_t1 | input | 13 | Horizontal blank first toggle pixel |
| cfg_hblk_t2 | input | 13 | Horizontal blank second toggle pixel |
| cfg_frz_en | input | 2 | Enables of freeze windows 1 and 2 |
| cfg_frz1_at | input | 13 | Freeze pixel of window 1 |
| cfg_res1_at | input | 13 | Resume pixel of window 1 |
| cfg_frz2_at | input | 13 | Freeze pixel of window 2 |
| cfg_res2_at | input | 13 | Resume pixel of window 2 |
| hd_n | output | 1 | Line pulse, low on pixel 0 |
| xv | output | 13 | Vertical clock outputs |
| clpob | output | 1 | Optical black clamp |
| pblk | output | 1 | Pre-blanking |
| hblk | output | 1 | Horizontal blanking |

## Verification
The bench sweeps all sixteen group pairings. The sweep covers repeat counts of zero and runs that are cut off at the line end, and start pixels that fall inside a freeze window. A design that dropped a pattern start which lands in a frozen pixel would leave the channel idle for the whole line. A design that kept advancing through a freeze would resume at a later offset, and both show up as wrong xv levels. Odd/even counts and the shorter last line are checked on every line, so a parity or last-line slip shows as a shifted hd_n or a wrong play count. One field runs at the full 8192-pixel line to catch a counter that wraps early. In another field the configuration inputs are changed after the latch, so a block that reads them live gives outputs that differ from the expected ones.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int GRP_W = 2;
  localparam int POS_W = 4;

  // Group length in pixels: 6 + 2g
  function automatic logic [POS_W-1:0] grp_len(input logic [GRP_W-1:0] g);
    return POS_W'(6 + 2 * int'(g));
  endfunction

  function automatic logic [POS_W-1:0] grp_t1(input logic [GRP_W-1:0] g, input int k);
    int s;
    s = ((k + int'(g)) % 3) + 1;
    return s[POS_W-1:0];
  endfunction

  function automatic logic [POS_W-1:0] grp_t2(input logic [GRP_W-1:0] g, input int k);
    return grp_t1(g, k) + POS_W'(2) + POS_W'(g);
  endfunction

  function automatic logic grp_pol(input logic [GRP_W-1:0] g, input int k);
    return (k % 2 == 1) ^ g[0];
  endfunction

  function automatic logic grp_lvl(input logic [GRP_W-1:0] g, input int k,
                                   input logic [POS_W-1:0] q);
    return grp_pol(g, k) ^ (q >= grp_t1(g, k)) ^ (q >= grp_t2(g, k));
  endfunction

  // Line-relative window: polarity flipped once per toggle pixel reached
  function automatic logic win_lvl(input logic pol, input int t1, input int t2, input int p);
    return pol ^ (p >= t1) ^ (p >= t2);
  endfunction
endpackage

// File: rtl/vseq_linecnt.sv
module vseq_linecnt #(
  parameter int PIX_W  = 13,
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [PIX_W-1:0]  line_len_m1,
  input  logic [PIX_W-1:0]  last_len_m1,
  input  logic [LINE_W-1:0] last_line,
  output logic [PIX_W-1:0]  pix,
  output logic              active,
  output logic              line_end,
  output logic              parity_odd,
  output logic              hd_n
);
  logic [LINE_W-1:0] line_q;
  logic              is_last;
  logic [PIX_W-1:0]  len_m1;

  assign is_last  = (line_q == last_line);
  assign len_m1   = is_last ? last_len_m1 : line_len_m1;
  assign line_end = active && (pix == len_m1);
  assign hd_n     = !(active && (pix == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix        <= '0;
      line_q     <= '0;
      active     <= 1'b0;
      parity_odd <= 1'b1;
    end else if (frame_start) begin
      pix        <= '0;
      line_q     <= '0;
      active     <= 1'b1;
      parity_odd <= 1'b1;
    end else if (line_end) begin
      pix        <= '0;
      parity_odd <= ~parity_odd;
      if (is_last) active <= 1'b0;
      else         line_q <= line_q + LINE_W'(1);
    end else if (active) begin
      pix <= pix + PIX_W'(1);
    end
  end

  AST_PIX_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pix <= len_m1)); // R1
  AST_FIELD_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(line_end) && $past(is_last))); // R2
  AST_PARITY_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !is_last && !frame_start) |=> (parity_odd != $past(parity_odd))); // R4
endmodule

// File: rtl/vseq_grp_engine.sv
module vseq_grp_engine import vseq_pkg::*; #(
  parameter int PIX_W  = 13,
  parameter int NUM_XV = 13,
  parameter int REP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              active,
  input  logic              line_end,
  input  logic              frozen,
  input  logic [PIX_W-1:0]  pix,
  input  logic [PIX_W-1:0]  start_pix,
  input  logic [GRP_W-1:0]  grp,
  input  logic [REP_W-1:0]  reps,
  output logic [NUM_XV-1:0] lvl
);
  logic             run_q;
  logic [POS_W-1:0] pos_q, cur_pos, glen;
  logic [REP_W-1:0] rep_q, cur_rep;
  logic             trig, cur_run, grp_done;

  assign glen     = grp_len(grp);
  assign trig     = active && !run_q && (pix == start_pix) && (reps != '0);
  assign cur_run  = run_q || trig;
  assign cur_pos  = run_q ? pos_q : '0;
  assign cur_rep  = run_q ? rep_q : '0;
  assign grp_done = (cur_pos + POS_W'(1)) == glen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pos_q <= '0;
      rep_q <= '0;
    end else if (frame_start || line_end || !active) begin
      run_q <= 1'b0;
      pos_q <= '0;
      rep_q <= '0;
    end else if (frozen) begin
      if (trig) begin
        run_q <= 1'b1;
        pos_q <= '0;
        rep_q <= '0;
      end
    end else if (cur_run) begin
      if (grp_done) begin
        pos_q <= '0;
        rep_q <= cur_rep + REP_W'(1);
        run_q <= (cur_rep + REP_W'(1)) != reps;
      end else begin
        pos_q <= cur_pos + POS_W'(1);
        rep_q <= cur_rep;
        run_q <= 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NUM_XV; k++) begin : g_out
    assign lvl[k] = cur_run ? grp_lvl(grp, k, cur_pos) : grp_pol(grp, k);
  end

  AST_POS_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    cur_run |-> (cur_pos < glen)); // R5
  AST_FREEZE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && run_q && !line_end && !frame_start && active) |=> (run_q && pos_q == $past(pos_q))); // R8
endmodule

// File: rtl/vseq_win_gen.sv
module vseq_win_gen import vseq_pkg::*; #(
  parameter int PIX_W = 13
) (
  input  logic             active,
  input  logic             pol,
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] t1,
  input  logic [PIX_W-1:0] t2,
  output logic             lvl
);
  assign lvl = active ? win_lvl(pol, int'(t1), int'(t2), int'(pix)) : pol;
endmodule

// File: rtl/vseq_timing_gen.sv
module vseq_timing_gen #(
  parameter int PIX_W  = 13,
  parameter int LINE_W = 8,
  parameter int NUM_XV = 13,
  parameter int REP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [PIX_W-1:0]  cfg_line_len_m1,
  input  logic [PIX_W-1:0]  cfg_last_len_m1,
  input  logic [LINE_W-1:0] cfg_last_line,
  input  logic [1:0]        cfg_grp_a,
  input  logic [1:0]        cfg_grp_b,
  input  logic [PIX_W-1:0]  cfg_start_a,
  input  logic [PIX_W-1:0]  cfg_start_b,
  input  logic [NUM_XV-1:0] cfg_use_b,
  input  logic [REP_W-1:0]  cfg_rep_odd,
  input  logic [REP_W-1:0]  cfg_rep_even,
  input  logic              cfg_clpob_pol,
  input  logic [PIX_W-1:0]  cfg_clpob_t1,
  input  logic [PIX_W-1:0]  cfg_clpob_t2,
  input  logic              cfg_pblk_pol,
  input  logic [PIX_W-1:0]  cfg_pblk_t1,
  input  logic [PIX_W-1:0]  cfg_pblk_t2,
  input  logic              cfg_hblk_pol,
  input  logic [PIX_W-1:0]  cfg_hblk_t1,
  input  logic [PIX_W-1:0]  cfg_hblk_t2,
  input  logic [1:0]        cfg_frz_en,
  input  logic [PIX_W-1:0]  cfg_frz1_at,
  input  logic [PIX_W-1:0]  cfg_res1_at,
  input  logic [PIX_W-1:0]  cfg_frz2_at,
  input  logic [PIX_W-1:0]  cfg_res2_at,
  output logic              hd_n,
  output logic [NUM_XV-1:0] xv,
  output logic              clpob,
  output logic              pblk,
  output logic              hblk
);
  localparam int NUM_CH  = 2;
  localparam int NUM_WIN = 3;

  typedef struct packed {
    logic [PIX_W-1:0]  line_m1, last_m1;
    logic [LINE_W-1:0] last_line;
    logic [1:0]        grp_a, grp_b;
    logic [PIX_W-1:0]  start_a, start_b;
    logic [NUM_XV-1:0] use_b;
    logic [REP_W-1:0]  rep_odd, rep_even;
    logic [NUM_WIN-1:0] wpol;
    logic [PIX_W-1:0]  c1, c2, p1, p2, h1, h2;
    logic [1:0]        frz_en;
    logic [PIX_W-1:0]  f1, r1, f2, r2;
  } cfg_t;

  cfg_t cfg_q;
  logic [PIX_W-1:0]  pix;
  logic              active, line_end, parity_odd, frz_now, frz_hit1, frz_hit2;
  logic [REP_W-1:0]  reps_cur;
  logic [NUM_XV-1:0] ch_lvl [NUM_CH];
  logic [1:0]        ch_grp [NUM_CH];
  logic [PIX_W-1:0]  ch_start [NUM_CH];
  logic [NUM_XV-1:0] xv_calc, xv_hold;
  logic [PIX_W-1:0]  win_t1 [NUM_WIN];
  logic [PIX_W-1:0]  win_t2 [NUM_WIN];
  logic [NUM_WIN-1:0] win_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (frame_start)
      cfg_q <= '{cfg_line_len_m1, cfg_last_len_m1, cfg_last_line, cfg_grp_a, cfg_grp_b,
                 cfg_start_a, cfg_start_b, cfg_use_b, cfg_rep_odd, cfg_rep_even,
                 {cfg_hblk_pol, cfg_pblk_pol, cfg_clpob_pol},
                 cfg_clpob_t1, cfg_clpob_t2, cfg_pblk_t1, cfg_pblk_t2, cfg_hblk_t1, cfg_hblk_t2,
                 cfg_frz_en, cfg_frz1_at, cfg_res1_at, cfg_frz2_at, cfg_res2_at};
  end

  vseq_linecnt #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .line_len_m1(cfg_q.line_m1), .last_len_m1(cfg_q.last_m1), .last_line(cfg_q.last_line),
    .pix(pix), .active(active), .line_end(line_end), .parity_odd(parity_odd), .hd_n(hd_n));

  assign frz_hit1 = cfg_q.frz_en[0] && (pix >= cfg_q.f1) && (pix < cfg_q.r1);
  assign frz_hit2 = cfg_q.frz_en[1] && (pix >= cfg_q.f2) && (pix < cfg_q.r2);
  assign frz_now  = active && (frz_hit1 || frz_hit2);
  assign reps_cur = parity_odd ? cfg_q.rep_odd : cfg_q.rep_even;

  assign ch_grp[0]   = cfg_q.grp_a;
  assign ch_grp[1]   = cfg_q.grp_b;
  assign ch_start[0] = cfg_q.start_a;
  assign ch_start[1] = cfg_q.start_b;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    vseq_grp_engine #(.PIX_W(PIX_W), .NUM_XV(NUM_XV), .REP_W(REP_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .active(active),
      .line_end(line_end), .frozen(frz_now), .pix(pix), .start_pix(ch_start[c]),
      .grp(ch_grp[c]), .reps(reps_cur), .lvl(ch_lvl[c]));
  end

  for (genvar k = 0; k < NUM_XV; k++) begin : g_map
    assign xv_calc[k] = cfg_q.use_b[k] ? ch_lvl[1][k] : ch_lvl[0][k];
  end

  assign xv = !active ? '0 : (frz_now ? xv_hold : xv_calc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xv_hold <= '0;
    else        xv_hold <= xv;
  end

  assign win_t1[0] = cfg_q.c1;  assign win_t2[0] = cfg_q.c2;
  assign win_t1[1] = cfg_q.p1;  assign win_t2[1] = cfg_q.p2;
  assign win_t1[2] = cfg_q.h1;  assign win_t2[2] = cfg_q.h2;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    vseq_win_gen #(.PIX_W(PIX_W)) u_win (
      .active(active), .pol(cfg_q.wpol[w]), .pix(pix),
      .t1(win_t1[w]), .t2(win_t2[w]), .lvl(win_out[w]));
  end

  assign clpob = win_out[0];
  assign pblk  = win_out[1];
  assign hblk  = win_out[2];

  AST_XV_HELD_IN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_now && $past(active)) |-> (xv == $past(xv))); // R8
  AST_HD_ONLY_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    !hd_n |-> (active && !frz_now || active)); // R1
  AST_IDLE_XV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !$past(active)) |-> (xv == '0 && hd_n)); // R2
endmodule

// File: tb/vseq_timing_gen_tb_top.sv
`timescale 1ns/1ps
module vseq_timing_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0;
  always #5 clk = ~clk;

  // port drivers
  logic [12:0] p_line, p_last, p_sa, p_sb, p_use, p_c1, p_c2, p_p1, p_p2, p_h1, p_h2;
  logic [12:0] p_f1, p_r1, p_f2, p_r2;
  logic [7:0]  p_nl;
  logic [1:0]  p_ga, p_gb, p_fen;
  logic [3:0]  p_ro, p_re;
  logic        p_cpol, p_ppol, p_hpol;
  // copies captured at frame start (expected side)
  logic [12:0] c_line, c_last, c_sa, c_sb, c_use, c_c1, c_c2, c_p1, c_p2, c_h1, c_h2;
  logic [12:0] c_f1, c_r1, c_f2, c_r2;
  logic [7:0]  c_nl;
  logic [1:0]  c_ga, c_gb, c_fen;
  logic [3:0]  c_ro, c_re;
  logic        c_cpol, c_ppol, c_hpol;

  logic        hd_n, clpob, pblk, hblk;
  logic [12:0] xv;

  vseq_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_line_len_m1(p_line), .cfg_last_len_m1(p_last), .cfg_last_line(p_nl),
    .cfg_grp_a(p_ga), .cfg_grp_b(p_gb), .cfg_start_a(p_sa), .cfg_start_b(p_sb),
    .cfg_use_b(p_use), .cfg_rep_odd(p_ro), .cfg_rep_even(p_re),
    .cfg_clpob_pol(p_cpol), .cfg_clpob_t1(p_c1), .cfg_clpob_t2(p_c2),
    .cfg_pblk_pol(p_ppol), .cfg_pblk_t1(p_p1), .cfg_pblk_t2(p_p2),
    .cfg_hblk_pol(p_hpol), .cfg_hblk_t1(p_h1), .cfg_hblk_t2(p_h2),
    .cfg_frz_en(p_fen), .cfg_frz1_at(p_f1), .cfg_res1_at(p_r1),
    .cfg_frz2_at(p_f2), .cfg_res2_at(p_r2),
    .hd_n(hd_n), .xv(xv), .clpob(clpob), .pblk(pblk), .hblk(hblk));

  int n_chk = 0, n_bad = 0;
  logic [12:0] prev_xv = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // R5 table, stated arithmetically
  function automatic int b_glen(int g); return 6 + 2 * g; endfunction
  function automatic int b_t1(int g, int k); return 1 + ((k + g) % 3); endfunction
  function automatic bit b_spol(int g, int k); return bit'((k % 2) ^ (g % 2)); endfunction
  function automatic bit b_lvl(int g, int k, int q);
    int n;
    n = (q >= b_t1(g, k) ? 1 : 0) + (q >= b_t1(g, k) + 2 + g ? 1 : 0);
    return b_spol(g, k) ^ bit'(n % 2);
  endfunction
  function automatic bit b_win(bit pol, int t1, int t2, int p);
    int n;
    n = (p >= t1 ? 1 : 0) + (p >= t2 ? 1 : 0);
    return pol ^ bit'(n % 2);
  endfunction
  function automatic bit b_frozen(int p);
    return (c_fen[0] && p >= int'(c_f1) && p < int'(c_r1)) ||
           (c_fen[1] && p >= int'(c_f2) && p < int'(c_r2));
  endfunction

  function automatic logic [12:0] b_calc(int l, int p);
    logic [12:0] res = '0;
    int reps;
    reps = (l % 2 == 0) ? int'(c_ro) : int'(c_re);
    for (int ch = 0; ch < 2; ch++) begin
      int g, st, ln, tot, q;
      bit run;
      g = ch ? int'(c_gb) : int'(c_ga);
      st = ch ? int'(c_sb) : int'(c_sa);
      ln = b_glen(g);
      run = 0; q = 0;
      if (p >= st && reps != 0) begin
        tot = 0;
        for (int i = st; i < p; i++) if (!b_frozen(i)) tot++;
        if (tot / ln < reps) begin run = 1; q = tot % ln; end
      end
      for (int k = 0; k < 13; k++)
        if (int'(c_use[k]) == ch) res[k] = run ? b_lvl(g, k, q) : b_spol(g, k);
    end
    return res;
  endfunction

  task automatic check_pixel(int l, int p, string tag);
    bit fz;
    logic [12:0] e;
    string t;
    fz = b_frozen(p);
    e = fz ? prev_xv : b_calc(l, p);
    if (fz) t = "R8";
    else if (tag != "") t = tag;
    else t = (l % 2) ? "R4" : "R5";
    check(xv === e, t, int'(xv), int'(e));
    prev_xv = e;
    check(hd_n === (p != 0), (l == int'(c_nl)) ? "R2" : "R1", int'(hd_n), int'(p != 0));
    check(clpob === b_win(c_cpol, int'(c_c1), int'(c_c2), p), "R7", int'(clpob),
          int'(b_win(c_cpol, int'(c_c1), int'(c_c2), p)));
    check(pblk === b_win(c_ppol, int'(c_p1), int'(c_p2), p), "R7", int'(pblk),
          int'(b_win(c_ppol, int'(c_p1), int'(c_p2), p)));
    check(hblk === b_win(c_hpol, int'(c_h1), int'(c_h2), p), "R7", int'(hblk),
          int'(b_win(c_hpol, int'(c_h1), int'(c_h2), p)));
  endtask

  task automatic idle_check();
    check(hd_n === 1'b1, "R2", int'(hd_n), 1);
    check(xv === '0, "R2", int'(xv), 0);
    check(clpob === c_cpol, "R2", int'(clpob), int'(c_cpol));
    check(pblk === c_ppol, "R2", int'(pblk), int'(c_ppol));
    check(hblk === c_hpol, "R2", int'(hblk), int'(c_hpol));
    prev_xv = '0;
  endtask

  task automatic capture();
    c_line = p_line; c_last = p_last; c_nl = p_nl; c_ga = p_ga; c_gb = p_gb;
    c_sa = p_sa; c_sb = p_sb; c_use = p_use; c_ro = p_ro; c_re = p_re;
    c_cpol = p_cpol; c_c1 = p_c1; c_c2 = p_c2; c_ppol = p_ppol; c_p1 = p_p1; c_p2 = p_p2;
    c_hpol = p_hpol; c_h1 = p_h1; c_h2 = p_h2;
    c_fen = p_fen; c_f1 = p_f1; c_r1 = p_r1; c_f2 = p_f2; c_r2 = p_r2;
  endtask

  task automatic run_frame(string tag, bit scramble);
    capture();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    if (scramble) begin // R3: live changes after the latch must not matter
      p_line = 13'd5; p_last = 13'd3; p_nl = 8'd0; p_ga = ~p_ga; p_gb = ~p_gb;
      p_sa = '0; p_sb = 13'd1; p_use = ~p_use; p_ro = 4'd9; p_re = 4'd0;
      p_cpol = ~p_cpol; p_c1 = '0; p_fen = 2'b11; p_f1 = '0; p_r1 = 13'd30;
      p_hpol = ~p_hpol; p_h2 = 13'd1;
    end
    for (int l = 0; l <= int'(c_nl); l++) begin
      int len;
      len = (l == int'(c_nl)) ? int'(c_last) + 1 : int'(c_line) + 1;
      for (int p = 0; p < len; p++) begin
        check_pixel(l, p, tag);
        @(negedge clk);
      end
    end
    idle_check();
  endtask

  initial begin : watchdog
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    p_line = '0; p_last = '0; p_nl = '0; p_ga = '0; p_gb = '0; p_sa = '0; p_sb = '0;
    p_use = '0; p_ro = '0; p_re = '0; p_cpol = 0; p_c1 = '0; p_c2 = '0; p_ppol = 0;
    p_p1 = '0; p_p2 = '0; p_hpol = 0; p_h1 = '0; p_h2 = '0; p_fen = '0;
    p_f1 = '0; p_r1 = '0; p_f2 = '0; p_r2 = '0;
    capture();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check(); // R2 reset state

    // sweep all group pairings
    for (int ga = 0; ga < 4; ga++) begin
      for (int gb = 0; gb < 4; gb++) begin
        p_line = 13'd39; p_last = 13'd29; p_nl = 8'd2;
        p_ga = 2'(ga); p_gb = 2'(gb);
        p_sa = 13'(2 + 3 * ga); p_sb = 13'(5 + 2 * gb);
        p_use = 13'(13'h1555 << ga) ^ 13'(gb * 13'h0111);
        p_ro = 4'((ga + 2 * gb) % 5); p_re = 4'((3 * ga + gb) % 4 + 1);
        if (ga == 3 && gb == 3) p_ro = 4'd15; // run cut at line end
        p_cpol = ga[0]; p_c1 = 13'd3; p_c2 = 13'd30;
        p_ppol = gb[0]; p_p1 = 13'd0; p_p2 = 13'(8 + ga);
        p_hpol = 1'b1; p_h1 = 13'd35; p_h2 = 13'd50;
        p_fen = 2'(ga ^ gb); p_f1 = 13'd10; p_r1 = 13'd14;
        p_f2 = 13'(20 + ga); p_r2 = 13'(26 + gb);
        run_frame(((ga + gb) % 2 == 1) ? "R6" : "", 1'b0);
      end
    end

    // full-length line, then short last line (R1, R2)
    p_line = 13'd8191; p_last = 13'd5; p_nl = 8'd1;
    p_ga = 2'd3; p_gb = 2'd2; p_sa = 13'd8180; p_sb = 13'd8000; p_use = 13'h0F0F;
    p_ro = 4'd1; p_re = 4'd2; p_fen = 2'b11; p_f1 = 13'd8185; p_r1 = 13'd8190;
    p_f2 = 13'd8100; p_r2 = 13'd8110; p_hpol = 1'b0; p_h1 = 13'd0; p_h2 = 13'd8191;
    run_frame("R1", 1'b0);

    // configuration changed after latch (R3)
    p_line = 13'd24; p_last = 13'd24; p_nl = 8'd3; p_ga = 2'd1; p_gb = 2'd2;
    p_sa = 13'd4; p_sb = 13'd7; p_use = 13'h0333; p_ro = 4'd2; p_re = 4'd1;
    p_fen = 2'b01; p_f1 = 13'd12; p_r1 = 13'd15; p_cpol = 1'b0; p_c1 = 13'd2; p_c2 = 13'd9;
    run_frame("R3", 1'b1);

    repeat (3) @(negedge clk);
    idle_check(); // R2 stays idle without a new strobe
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule